// File: doc/BRIEF.md
# Open-Drain Bus Arbitration Monitor

This block sits beside the data-line driver of a two-wire serial master and decides, one bit at a time, whether that master may keep driving the shared open-drain data line. While a transmission is active it asks for the line to be pulled low whenever the bit to send is 0, and leaves it released for a 1. On each SCL-high sample strobe it compares the bit it means to send with the level actually seen on the line.

Only one mismatch counts as a loss: the master leaves the line released (sends 1) but samples it low. Another master is then driving the line. From that moment the block stops pulling the line low, raises a latched lost flag and switches the master into receive mode. The winning master's transfer is therefore never disturbed.

The block keeps sampling the line on every strobe, so the master that lost can collect the rest of the transfer, including the bit on which it lost. The lost state is cleared by a detected STOP or by an explicit clear input.

Top module: `arb_monitor`

## Requirements
- R1: While rst_n is low, and at the first sample after reset, arb_lost, rx_mode, sda_pull and rx_valid are 0 and rx_bit is 1.
- R2: While tx_active is 1 and arb_lost is 0, sda_pull equals the inverse of tx_bit in the same cycle, with no register in the path. sda_pull=1 means pull the line low.
- R3: A clock edge at which scl_high_stb=1, tx_active=1, tx_bit=1 and sda_in=0 all hold sets arb_lost and rx_mode to 1 from that edge onward.
- R4: A strobe at which tx_bit equals sda_in does not set arb_lost. A strobe with tx_bit=0 and sda_in=1 does not set it either. A mismatch with scl_high_stb=0 has no effect.
- R5: While arb_lost is 1, sda_pull is 0 whatever tx_bit and tx_active are.
- R6: Once set, arb_lost holds until a clock edge at which stop_det or lost_clr is 1, which clears it. A clear wins over a loss condition at the same edge.
- R7: With tx_active=0, sda_pull is 0 and no strobe can set arb_lost.
- R8: At every clock edge with scl_high_stb=1, rx_bit takes sda_in. rx_valid is 1 for the cycle after each such edge at which arb_lost was already 1 or the loss condition of R3 held. Otherwise rx_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_active | input | 1 | A transmission by this master is in progress |
| tx_bit | input | 1 | Bit this master intends to place on the line |
| sda_in | input | 1 | Synchronised level of the data line |
| scl_high_stb | input | 1 | One-cycle strobe within the clock-high phase |
| stop_det | input | 1 | STOP condition seen on the bus |
| lost_clr | input | 1 | Explicit clear of the lost state |
| sda_pull | output | 1 | Request to pull the data line low |
| arb_lost | output | 1 | Latched arbitration-lost flag |
| rx_mode | output | 1 | Master must act as receiver |
| rx_bit | output | 1 | Last bit sampled from the line |
| rx_valid | output | 1 | rx_bit holds a bit received after or at the loss |

## Verification
sda_pull is combinational and settles in the same cycle as its inputs. arb_lost, rx_mode, rx_bit and rx_valid change at the first clock edge after the strobe or clear that causes them. The driver applies each stimulus at a falling edge and holds it through the next rising edge. The monitor compares one queued expectation 1 ns after that rising edge, so every registered result is read exactly one edge after its cause, and sda_pull is read with the updated lost state and the inputs still held.

// File: rtl/arb_monitor.sv
module arb_monitor (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_active,
  input  logic tx_bit,
  input  logic sda_in,
  input  logic scl_high_stb,
  input  logic stop_det,
  input  logic lost_clr,
  output logic sda_pull,
  output logic arb_lost,
  output logic rx_mode,
  output logic rx_bit,
  output logic rx_valid
);

  logic lost_q, rx_bit_q, rx_valid_q;
  logic loss_hit, clear_req;

  assign loss_hit  = scl_high_stb & tx_active & tx_bit & ~sda_in & ~lost_q;
  assign clear_req = stop_det | lost_clr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lost_q     <= 1'b0;
      rx_bit_q   <= 1'b1;
      rx_valid_q <= 1'b0;
    end else begin
      if (clear_req)     lost_q <= 1'b0;
      else if (loss_hit) lost_q <= 1'b1;
      if (scl_high_stb)  rx_bit_q <= sda_in;
      rx_valid_q <= scl_high_stb & (lost_q | loss_hit);
    end
  end

  assign sda_pull = tx_active & ~lost_q & ~tx_bit;
  assign arb_lost = lost_q;
  assign rx_mode  = lost_q;
  assign rx_bit   = rx_bit_q;
  assign rx_valid = rx_valid_q;

  a_r3_loss_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arb_lost) |-> $past(scl_high_stb & tx_active & tx_bit & ~sda_in));

  a_r5_released: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost |-> !sda_pull);

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_lost && !stop_det && !lost_clr) |=> arb_lost);

  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_det || lost_clr) |=> !arb_lost);

  a_r4_no_false_loss: assert property (@(posedge clk) disable iff (!rst_n)
    (!arb_lost && !(scl_high_stb && tx_bit && !sda_in)) |=> !arb_lost);

  a_r7_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_active && !arb_lost) |=> !arb_lost);

  a_r8_sample: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(scl_high_stb)) |-> (rx_bit == $past(sda_in)));

  a_r8_valid: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(scl_high_stb));

endmodule

// File: tb/arb_monitor_bench.sv
`timescale 1ns/1ps
module arb_monitor_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_active = 1'b0, tx_bit = 1'b0, sda_in = 1'b1, scl_high_stb = 1'b0;
  logic stop_det = 1'b0, lost_clr = 1'b0;
  logic sda_pull, arb_lost, rx_mode, rx_bit, rx_valid;

  int checks = 0;
  int errors = 0;
  logic [4:0] exp_q[$];
  string tag_q[$];
  logic m_lost = 1'b0, m_rxb = 1'b1, m_rxv = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  arb_monitor u_arb_monitor (
    .clk(clk), .rst_n(rst_n), .tx_active(tx_active), .tx_bit(tx_bit),
    .sda_in(sda_in), .scl_high_stb(scl_high_stb), .stop_det(stop_det),
    .lost_clr(lost_clr), .sda_pull(sda_pull), .arb_lost(arb_lost),
    .rx_mode(rx_mode), .rx_bit(rx_bit), .rx_valid(rx_valid));

  task automatic check(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %b expected %b", tag, what, act, exp);
    end
  endtask

  task automatic step(logic act, logic b, logic sda, logic stb, logic stp, logic clr, string tag);
    logic hit;
    @(negedge clk);
    tx_active = act; tx_bit = b; sda_in = sda; scl_high_stb = stb;
    stop_det = stp; lost_clr = clr;
    hit = stb && act && b && !sda && !m_lost;
    m_rxv = stb && (m_lost || hit);
    if (stb) m_rxb = sda;
    if (stp || clr) m_lost = 1'b0;
    else if (hit) m_lost = 1'b1;
    exp_q.push_back({act && !m_lost && !b, m_lost, m_lost, m_rxb, m_rxv});
    tag_q.push_back(tag);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rst_n && exp_q.size() > 0) begin
        logic [4:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, "sda_pull", sda_pull, e[4]);
        check(t, "arb_lost", arb_lost, e[3]);
        check(t, "rx_mode",  rx_mode,  e[2]);
        check(t, "rx_bit",   rx_bit,   e[1]);
        check(t, "rx_valid", rx_valid, e[0]);
      end
    end
  end

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1;
    check("R1", "arb_lost", arb_lost, 1'b0);
    check("R1", "rx_mode",  rx_mode,  1'b0);
    check("R1", "sda_pull", sda_pull, 1'b0);
    check("R1", "rx_bit",   rx_bit,   1'b1);
    check("R1", "rx_valid", rx_valid, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    step(0, 0, 1, 0, 0, 0, "R1");
    step(1, 0, 0, 0, 0, 0, "R2");
    step(1, 1, 1, 1, 0, 0, "R2");
    step(1, 0, 0, 1, 0, 0, "R4");
    step(1, 0, 1, 1, 0, 0, "R4");
    step(1, 1, 0, 0, 0, 0, "R4");
    step(1, 1, 0, 1, 0, 0, "R3");
    step(1, 0, 0, 0, 0, 0, "R5");
    step(1, 0, 1, 1, 0, 0, "R8");
    step(1, 1, 0, 1, 0, 0, "R8");
    step(0, 0, 0, 0, 0, 0, "R6");
    step(1, 0, 0, 0, 1, 0, "R6");
    step(0, 1, 0, 1, 0, 0, "R7");
    step(0, 0, 0, 0, 0, 0, "R7");
    step(1, 1, 0, 1, 0, 0, "R3");
    step(1, 1, 1, 0, 0, 1, "R6");
    step(1, 1, 0, 1, 0, 1, "R6");
    step(1, 0, 1, 0, 0, 0, "R2");
    for (int k = 0; k < 8; k++) step(1, k[0], k[0] | k[2], 1, 0, 0, "R4");
    step(1, 0, 0, 0, 1, 0, "R6");
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule